// File: doc/BRIEF.md
# Stream Parallel-to-Serial Width Downsizer

This block takes one wide word from an upstream streaming source and hands it to a narrow downstream sink as a sequence of equal slices. A wide word of `SLICE_CNT * SLICE_W` bits is accepted on the input side with a valid/ready handshake. It is stored in a slice register and then sent as `SLICE_CNT` narrow beats. The most significant slice goes first and the least significant slice goes last. A beat counter tracks the position inside the current word.

The input side is ready again in the same cycle in which the last beat of the current word is taken. A source that keeps its valid high therefore sees no idle cycle between words. The active level of the reset input is chosen by a parameter. Internally the reset asserts at once and releases in step with the clock. Packet boundaries are not carried: the output last flag stays low and the input last flag is ignored. A typical setting is 32-bit slices with four slices per word, which turns 128-bit words into 32-bit beats.

Top module: `stream_narrower`

## Requirements
- R1: While reset is active, and after it is released with no word yet taken, `m_valid` is low and `s_ready` is high.
- R2: A word is captured only in a cycle where `s_valid` and `s_ready` are both high. A beat is consumed only in a cycle where `m_valid` and `m_ready` are both high. With no word captured, `m_valid` stays low.
- R3: For a captured word `w`, beat k (k = 0 for the first beat) equals `w[(SLICE_CNT-k)*SLICE_W-1 -: SLICE_W]`. So the first beat is the top slice and the last beat is bits `[SLICE_W-1:0]`.
- R4: `s_ready` is high exactly when no word is in progress, or when the final beat of the current word is consumed in this cycle. With continuous supply and no backpressure, `m_valid` stays high across word boundaries.
- R5: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_beat` does not change in the next cycle.
- R6: After the final beat of a word is consumed, `m_valid` is low in the next cycle unless a new word was captured in that same cycle.
- R7: `m_last` is always low, and the value on `s_last` has no effect on any output.
- R8: With `RST_ACTIVE_HIGH = 1` the block resets on a high `rst_in`. With 0 it resets on a low `rst_in`. Apart from that, the two settings behave identically.
- R9: Every captured word yields exactly `SLICE_CNT` beats. No beat is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_in | input | 1 | Reset; active level set by `RST_ACTIVE_HIGH` |
| s_word | input | SLICE_CNT*SLICE_W | Wide input word |
| s_last | input | 1 | Input last flag, ignored |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Block can take a wide word |
| m_beat | output | SLICE_W | Narrow output beat |
| m_last | output | 1 | Output last flag, held low |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Sink takes the beat |

## Verification
Several rules are checked by assertions on every clocked cycle:
- the beat is held steady under backpressure,
- valid drops after the final beat when no new word arrives,
- the first beat after a capture is the top slice,
- the beat counter stays in range and restarts on every capture.

Other properties can only be shown by the bench scenarios under random gaps and random backpressure:
- the full MSB-first order of all later beats,
- the absence of lost or repeated beats,
- the exact `s_ready` timing at word boundaries,
- gap-free back-to-back operation,
- that `s_last` and the reset polarity setting make no difference.

// File: rtl/stream_narrower_pkg.sv
package stream_narrower_pkg;

  // Width of a counter that must hold values 0 .. n-1 (at least one bit).
  function automatic int count_bits(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/nrw_reset_cond.sv
module nrw_reset_cond #(
  parameter bit ACTIVE_HIGH = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_in,
  output logic rst_n_o
);

  logic                   rst_act_n;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;

  // Normalise the external reset to an active-low level.
  generate
    if (ACTIVE_HIGH) begin : g_high
      assign rst_act_n = ~rst_in;
    end else begin : g_low
      assign rst_act_n = rst_in;
    end
  endgenerate

  // Shift a one in from the bottom; the top stage drives the internal reset.
  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  // Asserts asynchronously, releases on the clock.
  always_ff @(posedge clk or negedge rst_act_n) begin
    if (!rst_act_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/nrw_beat_counter.sv
module nrw_beat_counter
  import stream_narrower_pkg::*;
#(
  parameter int SLICE_CNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic advance,
  output logic at_last
);

  localparam int                 CNT_W  = count_bits(SLICE_CNT);
  localparam logic [CNT_W-1:0]   LAST_C = CNT_W'(SLICE_CNT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // A capture restarts the count and takes priority over a consumed beat.
  always_comb begin
    cnt_en = load || advance;
    if (load) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign at_last = (cnt_q == LAST_C);

  assert_count_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_C);

  assert_restart_on_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == '0));

endmodule

// File: rtl/nrw_slice_shifter.sv
module nrw_slice_shifter #(
  parameter int SLICE_W   = 32,
  parameter int SLICE_CNT = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           load,
  input  logic                           advance,
  input  logic [SLICE_CNT*SLICE_W-1:0]   word_i,
  output logic [SLICE_W-1:0]             beat_o
);

  logic shift_en;

  assign shift_en = load || advance;

  // Slot j holds word slice j.
  // On each consumed beat, every slot takes the one below it, so the top slot
  // always presents the next slice in MSB-first order.
  for (genvar j = 0; j < SLICE_CNT; j++) begin : g_slot
    logic [SLICE_W-1:0] q;
    logic [SLICE_W-1:0] d;
    logic [SLICE_W-1:0] below;

    if (j == 0) begin : g_bottom
      assign below = '0;
    end else begin : g_inner
      assign below = g_slot[j-1].q;
    end

    always_comb begin
      if (load) begin
        d = word_i[j*SLICE_W +: SLICE_W];
      end else begin
        d = below;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (shift_en) begin
        q <= d;
      end
    end
  end

  assign beat_o = g_slot[SLICE_CNT-1].q;

endmodule

// File: rtl/stream_narrower.sv
module stream_narrower
  import stream_narrower_pkg::*;
#(
  parameter int SLICE_W         = 32,
  parameter int SLICE_CNT       = 4,
  parameter bit RST_ACTIVE_HIGH = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst_in,
  input  logic [SLICE_CNT*SLICE_W-1:0] s_word,
  input  logic                         s_last,
  input  logic                         s_valid,
  output logic                         s_ready,
  output logic [SLICE_W-1:0]           m_beat,
  output logic                         m_last,
  output logic                         m_valid,
  input  logic                         m_ready
);

  localparam int WORD_W = SLICE_W * SLICE_CNT;

  logic rst_n;
  logic valid_q;
  logic valid_d;
  logic at_last;
  logic load;
  logic advance;
  logic unused_last;

  nrw_reset_cond #(
    .ACTIVE_HIGH (RST_ACTIVE_HIGH),
    .SYNC_STAGES (2)
  ) u_rst (
    .clk     (clk),
    .rst_in  (rst_in),
    .rst_n_o (rst_n)
  );

  // Handshake decode.
  assign advance = valid_q && m_ready;
  assign s_ready = !valid_q || (m_ready && at_last);
  assign load    = s_valid && s_ready;

  always_comb begin
    valid_d = valid_q;
    if (load) begin
      valid_d = 1'b1;
    end else if (advance && at_last) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  nrw_beat_counter #(
    .SLICE_CNT (SLICE_CNT)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .advance (advance),
    .at_last (at_last)
  );

  nrw_slice_shifter #(
    .SLICE_W   (SLICE_W),
    .SLICE_CNT (SLICE_CNT)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .advance (advance),
    .word_i  (s_word),
    .beat_o  (m_beat)
  );

  assign m_valid     = valid_q;
  assign m_last      = 1'b0;
  assign unused_last = s_last;

  assert_hold_under_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_beat)));

  assert_drop_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && at_last && !s_valid) |=> !m_valid);

  assert_first_beat_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> (m_valid && (m_beat == $past(s_word[WORD_W-1 -: SLICE_W]))));

  assert_capture_sets_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_valid && !s_valid) |=> !m_valid);

endmodule

// File: tb/stream_narrower_tb_top.sv
module stream_narrower_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 32;
  localparam int N          = 4;
  localparam int TOT        = W * N;
  localparam int CONT_WORDS = 8;
  localparam int RAND_WORDS = 50;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [TOT-1:0] s_word;
  logic           s_last, s_valid, m_ready;
  logic           s_ready, m_last, m_valid;
  logic [W-1:0]   m_beat;
  logic           hi_s_ready, hi_m_last, hi_m_valid;
  logic [W-1:0]   hi_m_beat;

  always #(CLK_PERIOD/2) clk = ~clk;

  stream_narrower #(.SLICE_W(W), .SLICE_CNT(N), .RST_ACTIVE_HIGH(1'b0)) dut_i (
    .clk(clk), .rst_in(rst_n), .s_word(s_word), .s_last(s_last), .s_valid(s_valid),
    .s_ready(s_ready), .m_beat(m_beat), .m_last(m_last), .m_valid(m_valid), .m_ready(m_ready));

  stream_narrower #(.SLICE_W(W), .SLICE_CNT(N), .RST_ACTIVE_HIGH(1'b1)) dut_hi_i (
    .clk(clk), .rst_in(!rst_n), .s_word(s_word), .s_last(!s_last), .s_valid(s_valid),
    .s_ready(hi_s_ready), .m_beat(hi_m_beat), .m_last(hi_m_last), .m_valid(hi_m_valid),
    .m_ready(m_ready));

  logic [W-1:0] exp_q[$];
  int  checks = 0, errors = 0, beats_seen = 0;
  bit  run_mon = 0, cont_mode = 0, seen_beat = 0, finished = 0;
  bit  prev_stall = 0, prev_drop = 0;
  logic [W-1:0] prev_beat;

  function automatic void chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endfunction

  // Driver: offers one wide word after a gap and pushes its expected beats.
  task automatic send_word(input logic [TOT-1:0] w, input int gap);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      s_valid = 1'b0;
      s_word  = {4{32'($urandom)}};
      s_last  = 1'($urandom);
    end
    @(negedge clk);
    s_valid = 1'b1;
    s_word  = w;
    s_last  = 1'($urandom);
    #2;
    while (!s_ready) begin
      @(negedge clk);
      #2;
    end
    for (int k = 0; k < N; k++) exp_q.push_back(w[TOT-1-k*W -: W]);
  endtask

  function automatic logic [TOT-1:0] rand_word();
    logic [TOT-1:0] w;
    for (int k = 0; k < N; k++) w[k*W +: W] = W'($urandom);
    return w;
  endfunction

  // Monitor: drives backpressure, then compares the outputs against the scoreboard.
  always @(negedge clk) begin
    if (run_mon) begin
      m_ready = cont_mode ? 1'b1 : ($urandom % 4 != 0);
      #1;
      if (prev_stall) chk(m_valid && (m_beat == prev_beat), "R5 hold", 64'(m_beat), 64'(prev_beat));
      if (prev_drop)  chk(!m_valid, "R6 drop", 64'(m_valid), 64'd0);
      chk(s_ready == (!m_valid || (m_ready && exp_q.size() == 1)), "R4 ready",
          64'(s_ready), 64'(!m_valid || (m_ready && exp_q.size() == 1)));
      chk(!m_last && !hi_m_last, "R7 last low", 64'({m_last, hi_m_last}), 64'd0);
      chk({hi_s_ready, hi_m_valid, hi_m_beat} == {s_ready, m_valid, m_beat}, "R8 polarity",
          64'(hi_m_beat), 64'(m_beat));
      if (cont_mode && seen_beat) chk(m_valid, "R4 no gap", 64'(m_valid), 64'd1);
      if (m_valid) chk(exp_q.size() != 0, "R2 spurious beat", 64'(m_beat), 64'd0);
      prev_drop = 1'b0;
      if (m_valid && m_ready && exp_q.size() != 0) begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        chk(m_beat == e, "R3 order", 64'(m_beat), 64'(e));
        beats_seen++;
        if (cont_mode) seen_beat = 1'b1;
        prev_drop = (exp_q.size() == 0) && !(s_valid && s_ready);
      end
      prev_stall = m_valid && !m_ready;
      prev_beat  = m_beat;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; s_valid = 1'b0; s_last = 1'b0; m_ready = 1'b0; s_word = '0;
    repeat (5) @(negedge clk);
    #1;
    chk(!m_valid && s_ready, "R1 in reset", 64'({m_valid, s_ready}), 64'b01);
    chk(!hi_m_valid && hi_s_ready, "R8 in reset", 64'({hi_m_valid, hi_s_ready}), 64'b01);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(!m_valid && s_ready, "R1 after release", 64'({m_valid, s_ready}), 64'b01);
    run_mon = 1'b1;
    // Back-to-back words with no backpressure.
    cont_mode = 1'b1;
    for (int i = 0; i < CONT_WORDS; i++) send_word(rand_word(), 0);
    cont_mode = 1'b0;
    // Random gaps and random backpressure, plus edge patterns.
    send_word({TOT{1'b1}}, 2);
    send_word({{(TOT-W){1'b0}}, {W{1'b1}}}, 0);
    for (int i = 0; i < RAND_WORDS; i++) send_word(rand_word(), int'($urandom % 4));
    @(negedge clk);
    s_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    #2;
    chk(beats_seen == (CONT_WORDS + 2 + RAND_WORDS) * N, "R9 beat count",
        64'(beats_seen), 64'((CONT_WORDS + 2 + RAND_WORDS) * N));
    chk(!m_valid, "R6 idle at end", 64'(m_valid), 64'd0);
    finish_run();
  end

endmodule